// File: doc/BRIEF.md
# Signature Word Readout Command Handler

This block serves a custom read command that returns words of a factory-stored 384-bit signature from a passive tag. It sits behind the air-interface decoder. It receives the command as a serial bit stream framed by a start strobe and an end strobe. It checks the frame and decides whether to answer, stay silent, or send the tag back to the arbitrate state. If it answers, it serializes the reply one bit at a time, paced by the encoder that follows it.

The signature lives in a small read-only table inside the block, and its contents are set by parameters. A valid command in the open or secured state yields either the requested words or an overrun error. In both cases the reply is followed by the tag handle and a CRC-16. The inventory state and the current handle come in as inputs. The block never changes the state itself; it only raises a request to move to arbitrate.

Top module: `sigrd_top`

## Requirements
- R1: While reset is high, and after it is released with no command received, `tx_valid`, `tx_done` and `to_arbitrate` are all low.
- R2: A command is the 64 bits sent MSB first between `rx_sof` and `rx_eof`: opcode E008h (16 bits), word pointer (8), word count (8), handle (16) and CRC (16). A frame with any other bit count or opcode produces no output.
- R3: The receive CRC uses polynomial 1021h and is preset to FFFFh by the start strobe. The frame is accepted only when the register holds 1D0Fh after all 64 bits; otherwise there is no output.
- R4: In the open (code 4) or secured (code 5) state, a valid frame whose handle field differs from `cur_handle` produces no output.
- R5: A valid frame in ready (0), arbitrate (1), reply (2) or acknowledged (3) gives a single-cycle `to_arbitrate` pulse in the cycle after `rx_eof` is sampled, and no reply. In killed (6), or with the unused code 7, there is no output at all.
- R6: A successful reply is a header bit 0, then signature words pointer through pointer+count-1 (16 bits each, MSB first), then the handle, then the ones-complement of a CRC-16. That CRC is computed over every earlier reply bit (preset FFFFh, polynomial 1021h), so a receiver sees residue 1D0Fh.
- R7: If the count is 0, or the pointer is 24 or more, or pointer+count exceeds 24, the reply is instead a header bit 1, the 8-bit code 03h, the handle, and the CRC formed as in R6.
- R8: A range that ends exactly on word 23 (pointer+count = 24) gets a normal successful reply.
- R9: The first reply bit is valid in the second cycle after `rx_eof` is sampled. `tx_bit` holds while `tx_valid` is high until `tx_ready` is sampled, and each sampled `tx_ready` moves to the next bit.
- R10: When the last CRC bit is taken, `tx_valid` falls and `tx_done` pulses high for exactly one cycle.
- R11: A frame that completes while a reply is pending or being sent is discarded, with no effect on the reply in progress.
- R12: Signature word k (0 to 23) equals `SIG_SEED` XOR {k, k}, where k is written as two 8-bit bytes; the default seed is C35Ah.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Start-of-frame strobe (frame-sync seen) |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| rx_bit | input | 1 | Received command bit |
| rx_eof | input | 1 | End-of-frame strobe, on a cycle of its own after the last bit |
| tag_state | input | 3 | Inventory state code |
| cur_handle | input | 16 | Handle currently assigned to the tag |
| tx_ready | input | 1 | Encoder takes the current reply bit |
| tx_bit | output | 1 | Current reply bit |
| tx_valid | output | 1 | A reply bit is present |
| tx_done | output | 1 | One-cycle pulse after the final reply bit |
| to_arbitrate | output | 1 | One-cycle request to move the tag to arbitrate |

## Verification
The assertions assume certain things about the inputs. `rx_eof` never shares a cycle with a data bit or with `rx_sof`. `tag_state` and `cur_handle` hold steady from the last bit through the end strobe. `tx_ready` means something only while `tx_valid` is high. The stimulus follows all of these rules. Every frame is opened with `rx_sof`, bits are driven one per cycle, and the end strobe gets a cycle of its own. The state and handle change only between commands, and the ready pacing runs both at full rate and at one bit in three cycles, so bits held across stalls are exercised.

// File: rtl/sigrd_pkg.sv
package sigrd_pkg;

  localparam int          FRAME_BITS  = 64;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  typedef enum logic [2:0] {
    ST_READY   = 3'd0,
    ST_ARB     = 3'd1,
    ST_REPLY   = 3'd2,
    ST_ACK     = 3'd3,
    ST_OPEN    = 3'd4,
    ST_SECURED = 3'd5,
    ST_KILLED  = 3'd6
  } tag_state_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HDR  = 3'd1,
    PH_BODY = 3'd2,
    PH_HDL  = 3'd3,
    PH_CRC  = 3'd4
  } tx_phase_e;

  typedef struct packed {
    logic        is_err;
    logic [7:0]  ptr;
    logic [7:0]  cnt;
    logic [15:0] handle;
  } reply_req_t;

  // One serial CRC-16 step, MSB-first data
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/sigrd_rom.sv
module sigrd_rom #(
  parameter int          DEPTH = 24,
  parameter logic [15:0] SEED  = 16'hC35A
) (
  input  logic        clk,
  input  logic [7:0]  addr,
  output logic [15:0] q
);
  localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [8:0] LIMIT = 9'(DEPTH);

  logic [15:0] rom_w [DEPTH];

  // Contents derived from the seed: word k = SEED ^ {k, k}
  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    assign rom_w[k] = SEED ^ {8'(k), 8'(k)};
  end

  logic [AW-1:0] idx;
  always_comb idx = ({1'b0, addr} < LIMIT) ? addr[AW-1:0] : '0;

  // Registered read, no reset, so a block memory can be inferred
  always_ff @(posedge clk) q <= rom_w[idx];

endmodule

// File: rtl/sigrd_rx.sv
module sigrd_rx
  import sigrd_pkg::*;
#(
  parameter int          SIG_WORDS = 24,
  parameter logic [15:0] OPCODE    = 16'hE008
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic        rx_bit,
  input  logic        rx_eof,
  input  logic [2:0]  tag_state,
  input  logic [15:0] cur_handle,
  input  logic        busy,
  output logic [7:0]  ptr_q,
  output logic        launch,
  output reply_req_t  req,
  output logic        to_arb
);
  localparam logic [8:0] LIMIT   = 9'(SIG_WORDS);
  localparam logic [6:0] NB_FULL = 7'(FRAME_BITS);
  localparam logic [6:0] NB_PTR  = 7'd24;

  logic [FRAME_BITS-1:0] sr;
  logic [6:0]            nbits;
  logic                  in_frame;
  logic [15:0]           crc;

  // Frame capture and running CRC (preset at frame-sync)
  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      nbits    <= '0;
      in_frame <= 1'b0;
      crc      <= CRC_PRESET;
      ptr_q    <= '0;
    end else begin
      if (rx_sof) begin
        in_frame <= 1'b1;
        nbits    <= '0;
        crc      <= CRC_PRESET;
      end else if (rx_valid && in_frame) begin
        sr  <= {sr[FRAME_BITS-2:0], rx_bit};
        crc <= crc_step(crc, rx_bit);
        if (nbits <= NB_FULL) nbits <= nbits + 7'd1;
      end else if (rx_eof) begin
        in_frame <= 1'b0;
      end
      // Early pointer capture lets the table read settle before the end strobe
      if (nbits == NB_PTR) ptr_q <= sr[7:0];
    end
  end

  logic [15:0] f_op, f_hdl;
  logic [7:0]  f_ptr, f_cnt;
  assign f_op  = sr[63:48];
  assign f_ptr = sr[47:40];
  assign f_cnt = sr[39:32];
  assign f_hdl = sr[31:16];

  tag_state_e st;
  assign st = tag_state_e'(tag_state);

  logic frame_ok, is_live, is_pre, range_bad;
  always_comb begin
    frame_ok  = rx_eof && in_frame && !rx_sof && (nbits == NB_FULL) &&
                (f_op == OPCODE) && (crc == CRC_RESIDUE) && !busy;
    is_live   = (st == ST_OPEN) || (st == ST_SECURED);
    is_pre    = st inside {ST_READY, ST_ARB, ST_REPLY, ST_ACK};
    range_bad = (f_cnt == 8'd0) || ({1'b0, f_ptr} >= LIMIT) ||
                (({1'b0, f_ptr} + {1'b0, f_cnt}) > LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      launch <= 1'b0;
      to_arb <= 1'b0;
      req    <= '0;
    end else begin
      launch <= 1'b0;
      to_arb <= 1'b0;
      if (frame_ok) begin
        if (is_live && (f_hdl == cur_handle)) begin
          launch     <= 1'b1;
          req.is_err <= range_bad;
          req.ptr    <= f_ptr;
          req.cnt    <= f_cnt;
          req.handle <= f_hdl;
        end else if (is_pre) begin
          to_arb <= 1'b1;
        end
      end
    end
  end

  p_single_launch_r11: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);
  p_reply_or_arb_r5: assert property (@(posedge clk) disable iff (rst)
    launch |-> !to_arb);
  p_killed_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_eof && tag_state == 3'd6) |=> (!launch && !to_arb));

endmodule

// File: rtl/sigrd_tx.sv
module sigrd_tx
  import sigrd_pkg::*;
#(
  parameter int         SIG_WORDS = 24,
  parameter logic [7:0] ERR_CODE  = 8'h03
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        launch,
  input  reply_req_t  req,
  input  logic [15:0] rom_q,
  input  logic        tx_ready,
  output logic [7:0]  rd_ptr,
  output logic        busy,
  output logic        tx_bit,
  output logic        tx_valid,
  output logic        tx_done
);
  localparam logic [8:0] LIMIT = 9'(SIG_WORDS);

  tx_phase_e   phase;
  logic [15:0] sh;
  logic [3:0]  left;
  logic [3:0]  blen_m1;
  logic [7:0]  words;
  logic [15:0] crc, crc_nx, hdl;

  always_comb crc_nx = crc_step(crc, tx_bit);
  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      sh       <= '0;
      left     <= '0;
      blen_m1  <= '0;
      words    <= '0;
      rd_ptr   <= '0;
      crc      <= CRC_PRESET;
      hdl      <= '0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (launch) begin
          phase    <= PH_HDR;
          tx_valid <= 1'b1;
          tx_bit   <= req.is_err;
          crc      <= CRC_PRESET;
          hdl      <= req.handle;
          if (req.is_err) begin
            sh      <= {ERR_CODE, 8'h00};
            blen_m1 <= 4'd7;
            words   <= 8'd0;
          end else begin
            sh      <= rom_q;
            blen_m1 <= 4'd15;
            words   <= req.cnt;
            rd_ptr  <= req.ptr + 8'd1;
          end
        end
      end else if (tx_ready) begin
        if (phase != PH_CRC) crc <= crc_nx;
        unique case (phase)
          PH_HDR: begin
            phase  <= PH_BODY;
            tx_bit <= sh[15];
            sh     <= {sh[14:0], 1'b0};
            left   <= blen_m1;
          end
          PH_BODY: begin
            if (left != 4'd0) begin
              tx_bit <= sh[15];
              sh     <= {sh[14:0], 1'b0};
              left   <= left - 4'd1;
            end else if (words > 8'd1) begin
              tx_bit <= rom_q[15];
              sh     <= {rom_q[14:0], 1'b0};
              left   <= 4'd15;
              words  <= words - 8'd1;
              rd_ptr <= rd_ptr + 8'd1;
            end else begin
              phase  <= PH_HDL;
              tx_bit <= hdl[15];
              sh     <= {hdl[14:0], 1'b0};
              left   <= 4'd15;
            end
          end
          PH_HDL: begin
            if (left != 4'd0) begin
              tx_bit <= sh[15];
              sh     <= {sh[14:0], 1'b0};
              left   <= left - 4'd1;
            end else begin
              phase  <= PH_CRC;
              tx_bit <= ~crc_nx[15];
              sh     <= {~crc_nx[14:0], 1'b0};
              left   <= 4'd15;
            end
          end
          PH_CRC: begin
            if (left != 4'd0) begin
              tx_bit <= sh[15];
              sh     <= {sh[14:0], 1'b0};
              left   <= left - 4'd1;
            end else begin
              phase    <= PH_IDLE;
              tx_valid <= 1'b0;
              tx_done  <= 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  p_hold_bit_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_bit)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);
  p_done_ends_r10: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_valid && $past(tx_valid)));
  p_launch_idle_r11: assert property (@(posedge clk) disable iff (rst)
    launch |-> (phase == PH_IDLE));
  p_rom_in_range_r12: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BODY && words > 8'd1) |-> ({1'b0, rd_ptr} < LIMIT));

endmodule

// File: rtl/sigrd_top.sv
module sigrd_top
  import sigrd_pkg::*;
#(
  parameter int          SIG_WORDS = 24,
  parameter logic [15:0] SIG_SEED  = 16'hC35A,
  parameter logic [15:0] OPCODE    = 16'hE008,
  parameter logic [7:0]  ERR_CODE  = 8'h03
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic        rx_bit,
  input  logic        rx_eof,
  input  logic [2:0]  tag_state,
  input  logic [15:0] cur_handle,
  input  logic        tx_ready,
  output logic        tx_bit,
  output logic        tx_valid,
  output logic        tx_done,
  output logic        to_arbitrate
);
  logic [7:0]  ptr_q, rd_ptr, rom_addr;
  logic [15:0] rom_q;
  logic        launch, tx_busy, rx_busy;
  reply_req_t  req;

  assign rx_busy  = tx_busy || launch;
  assign rom_addr = tx_busy ? rd_ptr : ptr_q;

  sigrd_rx #(.SIG_WORDS(SIG_WORDS), .OPCODE(OPCODE)) u_rx (
    .clk(clk), .rst(rst),
    .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_eof(rx_eof),
    .tag_state(tag_state), .cur_handle(cur_handle), .busy(rx_busy),
    .ptr_q(ptr_q), .launch(launch), .req(req), .to_arb(to_arbitrate)
  );

  sigrd_rom #(.DEPTH(SIG_WORDS), .SEED(SIG_SEED)) u_rom (
    .clk(clk), .addr(rom_addr), .q(rom_q)
  );

  sigrd_tx #(.SIG_WORDS(SIG_WORDS), .ERR_CODE(ERR_CODE)) u_tx (
    .clk(clk), .rst(rst), .launch(launch), .req(req), .rom_q(rom_q),
    .tx_ready(tx_ready), .rd_ptr(rd_ptr), .busy(tx_busy),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_done(tx_done)
  );

  p_reply_follows_r9: assert property (@(posedge clk) disable iff (rst)
    launch |=> tx_valid);
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    rst |=> (!tx_valid && !tx_done && !to_arbitrate));

endmodule

// File: tb/sim_sigrd_top.sv
module sim_sigrd_top;
  logic clk = 1'b0, rst = 1'b1;
  logic sof = 1'b0, vld = 1'b0, rbit = 1'b0, eof = 1'b0, rdy = 1'b0;
  logic [2:0]  st  = 3'd4;
  logic [15:0] hdl = 16'h1234;
  logic tx_bit, tx_valid, tx_done, to_arb;

  sigrd_top u0 (
    .clk(clk), .rst(rst), .rx_sof(sof), .rx_valid(vld), .rx_bit(rbit),
    .rx_eof(eof), .tag_state(st), .cur_handle(hdl), .tx_ready(rdy),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_done(tx_done),
    .to_arbitrate(to_arb)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, rmode = 0, rcnt = 0, vkind = 0;
  string cur_req = "R1";
  bit fin = 1'b0;
  bit exp_q[$], pend_q[$], v_q[$], fq[$];
  bit exp_valid = 0, exp_done = 0, exp_arb = 0, lpend = 0;

  function automatic logic [15:0] crc_upd(logic [15:0] c, bit b);
    logic [15:0] n;
    n = {c[14:0], 1'b0};
    if (c[15] ^ b) n = n ^ 16'h1021;
    return n;
  endfunction

  function automatic logic [15:0] sigw(int k);
    return 16'hC35A ^ {k[7:0], k[7:0]};
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  // Reference model: advances on every edge from the driven inputs only
  always @(posedge clk) begin
    bit busy;
    if (rst) begin
      exp_q.delete(); exp_valid = 0; exp_done = 0; exp_arb = 0; lpend = 0;
    end else begin
      busy = exp_valid || lpend;
      exp_done = 0; exp_arb = 0;
      if (exp_valid && rdy) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) begin exp_valid = 0; exp_done = 1; end
      end
      if (lpend) begin exp_q = pend_q; exp_valid = 1; lpend = 0; end
      if (eof && !busy) begin
        if (vkind == 1) exp_arb = 1;
        else if (vkind == 2) begin pend_q = v_q; lpend = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !fin) begin
      chk(tx_valid == exp_valid, "tx_valid (R9 timing)", 32'(tx_valid), 32'(exp_valid));
      if (exp_valid && exp_q.size() > 0)
        chk(tx_bit == exp_q[0], "tx_bit (R6/R7 content)", 32'(tx_bit), 32'(exp_q[0]));
      chk(tx_done == exp_done, "tx_done (R10)", 32'(tx_done), 32'(exp_done));
      chk(to_arb == exp_arb, "to_arbitrate (R5)", 32'(to_arb), 32'(exp_arb));
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      rcnt++;
      rdy = (rmode == 0) ? 1'b1 : ((rcnt % 3) == 0);
    end
  end

  task automatic build_frame(logic [15:0] op, int p, int c, logic [15:0] h,
                             bit corrupt, bit drop);
    logic [47:0] body;
    logic [15:0] crc, cw;
    body = {op, p[7:0], c[7:0], h};
    crc = 16'hFFFF;
    fq.delete();
    for (int i = 47; i >= 0; i--) begin fq.push_back(body[i]); crc = crc_upd(crc, body[i]); end
    cw = ~crc;
    if (corrupt) cw = cw ^ 16'h0010;
    for (int i = 15; i >= 0; i--) fq.push_back(cw[i]);
    if (drop) void'(fq.pop_back());
  endtask

  task automatic build_reply(bit err, int p, int c, logic [15:0] h);
    logic [15:0] crc, w;
    crc = 16'hFFFF;
    v_q.delete();
    v_q.push_back(err); crc = crc_upd(crc, err);
    if (err) begin
      for (int i = 7; i >= 0; i--) begin v_q.push_back(1'(8'h03 >> i)); crc = crc_upd(crc, 1'(8'h03 >> i)); end
    end else begin
      for (int k = p; k < p + c; k++) begin
        w = sigw(k);
        for (int i = 15; i >= 0; i--) begin v_q.push_back(w[i]); crc = crc_upd(crc, w[i]); end
      end
    end
    for (int i = 15; i >= 0; i--) begin v_q.push_back(h[i]); crc = crc_upd(crc, h[i]); end
    w = ~crc;
    for (int i = 15; i >= 0; i--) v_q.push_back(w[i]);
  endtask

  task automatic send_frame();
    @(negedge clk); sof = 1;
    @(negedge clk); sof = 0;
    foreach (fq[i]) begin
      vld = 1; rbit = fq[i];
      @(negedge clk);
    end
    vld = 0; eof = 1;
    @(negedge clk); eof = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_valid || lpend || exp_done || exp_arb);
    repeat (3) @(negedge clk);
  endtask

  // kind: 0 = no output, 1 = arbitrate pulse, 2 = reply
  task automatic cmd(string rq, logic [15:0] op, int p, int c, logic [15:0] h,
                     bit corrupt, bit drop, int kind, bit wait_end);
    bit err;
    cur_req = rq;
    build_frame(op, p, c, h, corrupt, drop);
    if (kind == 2) begin
      err = (c == 0) || (p >= 24) || (p + c > 24);
      build_reply(err, p, c, h);
    end
    vkind = kind;
    send_frame();
    if (wait_end) wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    cur_req = "R1";
    chk(!tx_valid && !tx_done && !to_arb, "R1 outputs in reset",
        {29'd0, tx_valid, tx_done, to_arb}, 32'd0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !tx_done && !to_arb, "R1 outputs after reset",
        {29'd0, tx_valid, tx_done, to_arb}, 32'd0);

    st = 3'd4;  // open
    cmd("R6", 16'hE008, 0, 24, 16'h1234, 0, 0, 2, 1);
    st = 3'd5;  // secured
    cmd("R6", 16'hE008, 7, 2, 16'h1234, 0, 0, 2, 1);
    rmode = 1;
    cmd("R9", 16'hE008, 5, 3, 16'h1234, 0, 0, 2, 1);
    rmode = 0;
    st = 3'd4;
    cmd("R8", 16'hE008, 23, 1, 16'h1234, 0, 0, 2, 1);
    cmd("R8", 16'hE008, 16, 8, 16'h1234, 0, 0, 2, 1);
    cmd("R12", 16'hE008, 10, 4, 16'h1234, 0, 0, 2, 1);
    cmd("R7", 16'hE008, 3, 0, 16'h1234, 0, 0, 2, 1);
    cmd("R7", 16'hE008, 24, 1, 16'h1234, 0, 0, 2, 1);
    cmd("R7", 16'hE008, 20, 5, 16'h1234, 0, 0, 2, 1);
    cmd("R7", 16'hE008, 255, 255, 16'h1234, 0, 0, 2, 1);
    cmd("R3", 16'hE008, 0, 2, 16'h1234, 1, 0, 0, 1);
    cmd("R4", 16'hE008, 0, 2, 16'h4321, 0, 0, 0, 1);
    cmd("R2", 16'hE009, 0, 2, 16'h1234, 0, 0, 0, 1);
    cmd("R2", 16'hE008, 0, 2, 16'h1234, 0, 1, 0, 1);

    st = 3'd0; cmd("R5", 16'hE008, 0, 2, 16'h1234, 0, 0, 1, 1);  // ready
    st = 3'd1; cmd("R5", 16'hE008, 0, 2, 16'h9999, 0, 0, 1, 1);  // arbitrate
    st = 3'd2; cmd("R5", 16'hE008, 0, 0, 16'h1234, 0, 0, 1, 1);  // reply
    st = 3'd3; cmd("R5", 16'hE008, 4, 4, 16'h1234, 0, 0, 1, 1);  // acknowledged
    st = 3'd6; cmd("R5", 16'hE008, 0, 2, 16'h1234, 0, 0, 0, 1);  // killed
    st = 3'd7; cmd("R5", 16'hE008, 0, 2, 16'h1234, 0, 0, 0, 1);  // unused code

    st = 3'd4; rmode = 1;
    cmd("R11", 16'hE008, 0, 24, 16'h1234, 0, 0, 2, 0);
    cmd("R11", 16'hE008, 2, 2, 16'h1234, 0, 0, 2, 1);
    rmode = 0;
    cmd("R10", 16'hE008, 1, 1, 16'h1234, 0, 0, 2, 1);

    cur_req = "R11";
    chk(exp_q.size() == 0 && !tx_valid, "R11 nothing left queued",
        32'(exp_q.size()), 32'd0);
    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule